// File: doc/BRIEF.md
# Reference and receive clock monitor

This block supervises two clocks from a free-running system clock. Each monitored clock reaches it as a toggle signal that is already synchronized into the system domain. Every change of level counts as one edge. The block reports two things: whether the reference clock has stopped, and whether the chosen receive clock runs close enough to the reference frequency to be called locked.

Frequency is measured over windows of a fixed number of reference edges. Within each window the block counts the receive-clock edges and compares that count with an expected value. Two ppm limits turn into count tolerances. The wide limit drops lock and the narrow limit restores it, and any deviation between the two leaves the flag unchanged. A select input picks the receive clock to measure: either the external receive clock or the recovered clock.

The reference is declared lost after a set number of system clocks with no reference edge. The loss flag is not latched: it falls as soon as reference edges return. While the reference is lost, the lock flag is held low and the measurement window is frozen.

Top module: `clk_health_mon`

## Requirements
- R1: In the cycle after a synchronous reset is released, both `ref_lost_o` and `rx_lock_o` are 0.
- R2: `ref_lost_o` rises after the TIMEOUT-th consecutive system clock edge without a reference edge, counted from reset or from the last reference edge, and not earlier. A reference edge is any change of level on `ref_tgl_i`.
- R3: `ref_lost_o` is not latched. It returns to 0 after the first clock edge at which a reference edge is seen.
- R4: A window closes on every REF_WIN-th reference edge. Its receive count covers every receive edge seen from the cycle after the previous window closed up to and including the closing cycle. A receive edge is any change of level on the selected toggle input.
- R5: At a window close with `rx_lock_o` = 1, lock drops to 0 when |count - EXP_CNT| > floor(EXP_CNT*DROP_PPM/1e6).
- R6: At a window close with `rx_lock_o` = 0, lock rises to 1 only when |count - EXP_CNT| <= floor(EXP_CNT*RECOVER_PPM/1e6). A deviation between the two tolerances leaves lock unchanged, and lock changes only at a window close or on reference loss.
- R7: `rx_sel_i` = 0 measures `ext_rx_tgl_i` and `rx_sel_i` = 1 measures `rec_rx_tgl_i`. The unselected input has no effect, and changing the select creates no edge.
- R8: While `ref_lost_o` is 1, `rx_lock_o` is 0 and receive edges are not counted. Lock falls in the same cycle that loss is declared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tgl_i | input | 1 | Synchronized reference toggle; each level change is one edge |
| ext_rx_tgl_i | input | 1 | Synchronized external receive-clock toggle |
| rec_rx_tgl_i | input | 1 | Synchronized recovered-clock toggle |
| rx_sel_i | input | 1 | 0 = measure external receive clock, 1 = measure recovered clock |
| ref_lost_o | output | 1 | High while the reference has stopped toggling |
| rx_lock_o | output | 1 | High while the receive clock meets the lock criteria |

## Verification
The bench places the receive count exactly one and two edges off nominal on both sides. A design that confused the drop and recovery tolerances, or that dropped hysteresis, would flip lock on a one-edge deviation or fail to recover on an exact match. It also probes the loss timeout one clock before and at the limit, where an off-by-one counter would flag early or late. It toggles the measured input many times while the reference is absent; a design that kept counting would see a huge deviation and never relock. Random windows switch the select and toggle the unused input freely, so any leakage from that input, or a false edge created by switching the select, shows up as a wrong lock decision.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  // Index of each monitored toggle inside the edge bank.
  localparam int SRC_REF = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_REC = 2;
  localparam int SRC_N   = 3;

  // Converts a ppm limit into a whole count tolerance (truncated).
  function automatic int ppm_tol(input int base, input int ppm);
    longint prod;
    prod = longint'(base) * longint'(ppm);
    return int'(prod / 64'd1000000);
  endfunction

endpackage

// File: rtl/clkmon_edge_bank.sv
module clkmon_edge_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic [N-1:0] tgl_i,
  output logic [N-1:0] edge_o
);
  logic [N-1:0] last_q;

  // The previous level is tracked even in reset, so no false edge follows it.
  always_ff @(posedge clk) begin
    last_q <= tgl_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign edge_o[i] = tgl_i[i] ^ last_q[i];
  end
endmodule

// File: rtl/clkmon_ref_watch.sv
module clkmon_ref_watch #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_edge_i,
  output logic lost_o,
  output logic lost_set_o
);
  localparam int IW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [IW-1:0] IDLE_LAST = IW'(TIMEOUT - 1);

  logic [IW-1:0] idle_q;
  logic          lost_q;

  // One-cycle pulse in the cycle that loss is being declared.
  assign lost_set_o = !ref_edge_i && !lost_q && (idle_q == IDLE_LAST);
  assign lost_o     = lost_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= '0;
      lost_q <= 1'b0;
    end else if (ref_edge_i) begin
      idle_q <= '0;
      lost_q <= 1'b0;
    end else if (idle_q == IDLE_LAST) begin
      lost_q <= 1'b1;
    end else begin
      idle_q <= idle_q + 1'b1;
    end
  end
endmodule

// File: rtl/clkmon_freq_win.sv
module clkmon_freq_win #(
  parameter int REF_WIN     = 20000,
  parameter int EXP_CNT     = 20000,
  parameter int DROP_PPM    = 500,
  parameter int RECOVER_PPM = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_edge_i,
  input  logic rx_edge_i,
  input  logic lost_i,
  input  logic lost_set_i,
  output logic done_o,
  output logic lock_o
);
  localparam int RW       = $clog2(REF_WIN);
  localparam int CW       = $clog2(2 * EXP_CNT + 4);
  localparam int DROP_TOL = clkmon_pkg::ppm_tol(EXP_CNT, DROP_PPM);
  localparam int REC_TOL  = clkmon_pkg::ppm_tol(EXP_CNT, RECOVER_PPM);
  localparam logic [RW-1:0] REF_LAST = RW'(REF_WIN - 1);
  localparam logic [CW-1:0] EXP_V    = CW'(EXP_CNT);
  localparam logic [CW-1:0] DROP_V   = CW'(DROP_TOL);
  localparam logic [CW-1:0] REC_V    = CW'(REC_TOL);
  localparam logic [CW-1:0] CNT_MAX  = '1;

  logic [RW-1:0] ref_cnt_q;
  logic [CW-1:0] rx_cnt_q;
  logic [CW-1:0] total;
  logic [CW-1:0] dev;
  logic          lock_q;
  logic          hold;
  logic          done;
  logic          far;
  logic          near;

  // Counting freezes while the reference is lost, except on the edge that ends it.
  assign hold = lost_i && !ref_edge_i;
  assign done = ref_edge_i && (ref_cnt_q == REF_LAST);

  always_comb begin
    total = rx_cnt_q;
    if (rx_edge_i && (rx_cnt_q != CNT_MAX)) total = rx_cnt_q + 1'b1;
    dev  = (total >= EXP_V) ? (total - EXP_V) : (EXP_V - total);
    far  = dev > DROP_V;
    near = dev <= REC_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_cnt_q <= '0;
      rx_cnt_q  <= '0;
      lock_q    <= 1'b0;
    end else if (done) begin
      ref_cnt_q <= '0;
      rx_cnt_q  <= '0;
      lock_q    <= lock_q ? !far : near;
    end else begin
      if (!hold) begin
        if (ref_edge_i) ref_cnt_q <= ref_cnt_q + 1'b1;
        rx_cnt_q <= total;
      end
      if (lost_set_i || lost_i) lock_q <= 1'b0;
    end
  end

  assign done_o = done;
  assign lock_o = lock_q;
endmodule

// File: rtl/clk_health_mon.sv
module clk_health_mon #(
  parameter int REF_WIN     = 20000,
  parameter int EXP_CNT     = 20000,
  parameter int DROP_PPM    = 500,
  parameter int RECOVER_PPM = 100,
  parameter int TIMEOUT     = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_tgl_i,
  input  logic ext_rx_tgl_i,
  input  logic rec_rx_tgl_i,
  input  logic rx_sel_i,
  output logic ref_lost_o,
  output logic rx_lock_o
);
  import clkmon_pkg::*;

  logic [SRC_N-1:0] tgl_bus;
  logic [SRC_N-1:0] edge_bus;
  logic             ref_edge_w;
  logic             rx_edge_w;
  logic             lost_set_w;
  logic             win_done_w;

  always_comb begin
    tgl_bus          = '0;
    tgl_bus[SRC_REF] = ref_tgl_i;
    tgl_bus[SRC_EXT] = ext_rx_tgl_i;
    tgl_bus[SRC_REC] = rec_rx_tgl_i;
  end

  clkmon_edge_bank #(.N(SRC_N)) u_edges (
    .clk    (clk),
    .tgl_i  (tgl_bus),
    .edge_o (edge_bus)
  );

  // Edges are found per source before the select, so switching adds none.
  assign ref_edge_w = edge_bus[SRC_REF];
  assign rx_edge_w  = rx_sel_i ? edge_bus[SRC_REC] : edge_bus[SRC_EXT];

  clkmon_ref_watch #(.TIMEOUT(TIMEOUT)) u_watch (
    .clk        (clk),
    .rst        (rst),
    .ref_edge_i (ref_edge_w),
    .lost_o     (ref_lost_o),
    .lost_set_o (lost_set_w)
  );

  clkmon_freq_win #(
    .REF_WIN     (REF_WIN),
    .EXP_CNT     (EXP_CNT),
    .DROP_PPM    (DROP_PPM),
    .RECOVER_PPM (RECOVER_PPM)
  ) u_freq (
    .clk        (clk),
    .rst        (rst),
    .ref_edge_i (ref_edge_w),
    .rx_edge_i  (rx_edge_w),
    .lost_i     (ref_lost_o),
    .lost_set_i (lost_set_w),
    .done_o     (win_done_w),
    .lock_o     (rx_lock_o)
  );
endmodule

// File: rtl/clk_health_mon_chk.sv
module clk_health_mon_chk (
  input logic clk,
  input logic rst,
  input logic ref_edge,
  input logic win_done,
  input logic ref_lost_o,
  input logic rx_lock_o
);
  // R2: loss is only declared after a clock without a reference edge
  p_lost_after_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_lost_o) |-> $past(!ref_edge));

  // R3: a reference edge always clears the loss flag on the next clock
  p_lost_clears_r3: assert property (@(posedge clk) disable iff (rst)
    ref_edge |=> !ref_lost_o);

  // R8: lock is never reported while the reference is absent
  p_lock_low_when_lost_r8: assert property (@(posedge clk) disable iff (rst)
    ref_lost_o |-> !rx_lock_o);

  // R6: lock can only rise as a window closes
  p_lock_rise_at_window_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_lock_o) |-> $past(win_done));

  // R5: lock falls only at a window close or on reference loss
  p_lock_fall_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_lock_o) |-> ($past(win_done) || ref_lost_o));
endmodule

bind clk_health_mon clk_health_mon_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ref_edge   (ref_edge_w),
  .win_done   (win_done_w),
  .ref_lost_o (ref_lost_o),
  .rx_lock_o  (rx_lock_o)
);

// File: tb/sim_clk_health_mon.sv
module sim_clk_health_mon;
  localparam int WIN      = 2000;
  localparam int EXP      = 2000;
  localparam int DROP_PPM = 500;
  localparam int REC_PPM  = 100;
  localparam int TO       = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_t = 1'b0;
  logic ext_t = 1'b0;
  logic rec_t = 1'b0;
  logic sel = 1'b0;
  logic lost, lock;

  int checks = 0;
  int fails  = 0;
  bit lock_m = 1'b0;

  always #5 clk = ~clk;

  clk_health_mon #(
    .REF_WIN(WIN), .EXP_CNT(EXP), .DROP_PPM(DROP_PPM),
    .RECOVER_PPM(REC_PPM), .TIMEOUT(TO)
  ) u0 (
    .clk(clk), .rst(rst), .ref_tgl_i(ref_t), .ext_rx_tgl_i(ext_t),
    .rec_rx_tgl_i(rec_t), .rx_sel_i(sel), .ref_lost_o(lost), .rx_lock_o(lock)
  );

  function automatic int tol(input int ppm);
    return int'((longint'(EXP) * ppm) / 1000000);
  endfunction

  function automatic bit next_lock(input bit cur, input int d);
    int a;
    a = (d < 0) ? -d : d;
    if (cur) return !(a > tol(DROP_PPM));
    return a <= tol(REC_PPM);
  endfunction

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drives one system clock; the unselected receive input gets random toggles.
  task automatic cyc(input bit r, input bit x);
    bit junk;
    junk = 1'($urandom_range(1));
    if (r) ref_t = ~ref_t;
    if (sel) begin
      if (x) rec_t = ~rec_t;
      if (junk) ext_t = ~ext_t;
    end else begin
      if (x) ext_t = ~ext_t;
      if (junk) rec_t = ~rec_t;
    end
    @(negedge clk);
  endtask

  // One full window whose receive count is EXP + d (R4).
  task automatic window(input int d, input bit chk_clear, input string req);
    int nmiss, nextra;
    nmiss  = (d < 0) ? -d : 0;
    nextra = (d > 0) ? d : 0;
    for (int k = 0; k < WIN; k++) begin
      cyc(1'b1, k >= nmiss);
      if (k == 0 && chk_clear) chk(lost, 1'b0, "R3 loss clears on first reference edge");
      if (k < nextra) cyc(1'b0, 1'b1);
    end
    lock_m = next_lock(lock_m, d);
    chk(lock, lock_m, req);
    chk(lost, 1'b0, "R2 no loss while reference toggles");
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk(lost, 1'b0, "R1 reset loss flag");
    chk(lock, 1'b0, "R1 reset lock flag");

    // R2: timeout boundary counted from reset
    for (int i = 0; i < TO - 1; i++) cyc(1'b0, 1'b0);
    chk(lost, 1'b0, "R2 no loss one clock before timeout");
    cyc(1'b0, 1'b0);
    chk(lost, 1'b1, "R2 loss at timeout");
    chk(lock, 1'b0, "R8 lock low while lost");

    // R8: receive edges during loss must not be counted
    for (int i = 0; i < 40; i++) cyc(1'b0, 1'b1);
    chk(lost, 1'b1, "R3 loss stays while reference is absent");
    window(0, 1'b1, "R8 edges during loss ignored, exact count locks");

    // Hysteresis around the two tolerances
    window(1,  1'b0, "R6 one off keeps lock");
    window(-1, 1'b0, "R6 one under keeps lock");
    window(2,  1'b0, "R5 two over drops lock");
    window(-1, 1'b0, "R6 one off does not relock");
    window(0,  1'b0, "R6 exact count relocks");
    window(-2, 1'b0, "R5 two under drops lock");
    window(3,  1'b0, "R5 stays unlocked on large deviation");
    window(0,  1'b0, "R6 relock");

    // Random windows with select switching and noise on the other input (R7)
    for (int w = 0; w < 12; w++) begin
      sel = 1'($urandom_range(1));
      window(int'($urandom_range(6)) - 3, 1'b0, "R7 random window on selected source");
    end

    // Loss while locked forces lock low in the same cycle (R8)
    sel = 1'b0;
    window(0, 1'b0, "R6 lock before loss");
    for (int i = 0; i < TO; i++) cyc(1'b0, 1'b0);
    chk(lost, 1'b1, "R2 loss after timeout from last edge");
    chk(lock, 1'b0, "R8 lock falls with loss");
    lock_m = 1'b0;
    sel = 1'b1;
    window(1, 1'b1, "R8 no relock on one-off after loss");
    window(0, 1'b0, "R7 recovered source relocks");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule